// File: doc/BRIEF.md
# DMA Channel Trigger and Auto-Initiation Controller

This block is the control core of one DMA channel. It decides when a block transfer begins, when it starts again and when it stops. Its inputs are a software request, a hardware request line, a hardware-enable bit and an auto-repeat mode bit. Single-cycle command inputs write the configuration: they set or clear the hardware enable, write the auto-repeat mode bit, store the element count of the control packet, issue a software start and ask for a software stop. A bus-error input aborts the running block.

A down-counter stands in for the transfer engine. It is loaded from the stored element count at every block start, and it marks the end of a block when its last element has passed. With auto-repeat on, the two kinds of start behave differently. A block started by software starts again at once, with no new request, until software stops it. A block started by hardware keeps its hardware enable, but the channel then goes idle until the next hardware request.

Top module: `dma_chan_ctl`

## Requirements
- R1: After reset, `busy`, `blk_done` and `hwen` are all 0 and the auto-repeat mode bit is off.
- R2: A `hwen_set` pulse makes `hwen` 1 from the next cycle. A `hwen_clr` pulse makes it 0 from the next cycle. When both arrive in the same cycle, `hwen` is 0.
- R3: A block start loads the stored element count N. A stored count of 0 is treated as 1. `busy` goes high on the start edge, and `blk_done` is a one-cycle pulse exactly N cycles after that edge. The largest count, 2^CNT_W-1, gives that many cycles. `blk_done` is never high unless the channel was busy in the cycle before.
- R4: When auto-repeat is off, `hwen` clears itself at the end of every block, whether software or hardware started it.
- R5: When auto-repeat is on, `hwen` stays set at the end of a block. The channel goes idle after a hardware-started block, and each later `hw_req` starts one more block.
- R6: While `hwen` is 0, `hw_req` never starts a block, whatever the auto-repeat setting.
- R7: When auto-repeat is on, a software-started block restarts back to back with the same count, giving one `blk_done` every N cycles. A `chan_dis` pulse lets the running block finish and then stops the restarts.
- R8: When auto-repeat is off, a software-started block runs once and the channel goes idle. A `sw_req` while the channel is busy is ignored.
- R9: A `bus_err` while the channel is busy aborts the block. From the next cycle `busy` is 0 and `hwen` is 0, and no `blk_done` follows. Any pending restart or pending request is cancelled. A `bus_err` while the channel is idle has no effect.
- R10: A `hw_req` that arrives while a block is running is held as pending. It starts a new block right after that block ends, but only if `hwen` is still set at that boundary.
- R11: When the channel is idle and `sw_req` and `hw_req` arrive in the same cycle, the block is treated as software-started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pkt_wr | input | 1 | Store `pkt_cnt` as the control packet element count |
| pkt_cnt | input | CNT_W | Element count to store |
| aim_wr | input | 1 | Write the auto-repeat mode bit |
| aim_val | input | 1 | Auto-repeat value to write (1 = on) |
| hwen_set | input | 1 | Set the hardware enable |
| hwen_clr | input | 1 | Clear the hardware enable |
| sw_req | input | 1 | Software start request |
| chan_dis | input | 1 | Software stop at the next block boundary |
| hw_req | input | 1 | Hardware request pulse |
| bus_err | input | 1 | Bus error on the active channel |
| busy | output | 1 | A block is in progress |
| blk_done | output | 1 | One-cycle pulse at the end of a block |
| hwen | output | 1 | Current hardware-enable state |

## Verification
The bench builds the block with CNT_W = 5. This keeps the largest element count at 31, so the full-count boundary can be timed cycle by cycle in a short run. The same small width lets back-to-back software restarts be counted over a fixed 20-cycle window for counts of 1, 4 and 5. Counts of 0 and 1 bring the restart-every-cycle case within reach. Short counts also let a pending hardware request, a mid-block stop and a mid-block bus error each land inside a running block.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
    typedef enum logic {
        SRC_HW = 1'b0,
        SRC_SW = 1'b1
    } trig_src_e;
endpackage

// File: rtl/dma_elem_cnt.sv
module dma_elem_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             last
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cnt = load_val;
        end else if (run && st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign last = (st_q.cnt == ONE);
endmodule

// File: rtl/dma_hwen_reg.sv
module dma_hwen_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    input  logic auto_clr,
    output logic en
);
    typedef struct packed {
        logic en;
    } hwen_st_t;

    hwen_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_req)              st_d.en = 1'b1;
        if (clr_req || auto_clr)  st_d.en = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en = st_q.en;
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
    import dma_chan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sw_req,
    input  logic hw_req,
    input  logic chan_dis,
    input  logic bus_err,
    input  logic hwen,
    input  logic hwen_clr,
    input  logic aim,
    input  logic last,
    output logic busy,
    output logic blk_done,
    output logic load,
    output logic auto_clr
);
    typedef struct packed {
        logic      busy;
        logic      done;
        logic      pend;
        logic      stop;
        trig_src_e src;
    } seq_st_t;

    seq_st_t st_d, st_q;

    logic abort;
    logic blk_end;
    logic stop_eff;
    logic restart_sw;
    logic serve_hw;

    always_comb begin
        abort      = st_q.busy && bus_err;
        blk_end    = st_q.busy && last && !bus_err;
        stop_eff   = st_q.stop || chan_dis;
        restart_sw = (st_q.src == SRC_SW) && aim && !stop_eff;
        serve_hw   = (st_q.pend || hw_req) && hwen && aim && !hwen_clr;

        st_d      = st_q;
        st_d.done = 1'b0;
        load      = 1'b0;

        if (abort) begin
            st_d.busy = 1'b0;
            st_d.pend = 1'b0;
            st_d.stop = 1'b0;
            st_d.src  = SRC_HW;
        end else if (st_q.busy) begin
            if (hw_req)   st_d.pend = 1'b1;
            if (chan_dis) st_d.stop = 1'b1;
            if (blk_end) begin
                st_d.done = 1'b1;
                st_d.pend = 1'b0;
                st_d.stop = 1'b0;
                if (restart_sw) begin
                    load     = 1'b1;
                    st_d.src = SRC_SW;
                end else if (serve_hw) begin
                    load     = 1'b1;
                    st_d.src = SRC_HW;
                end else begin
                    st_d.busy = 1'b0;
                    st_d.src  = SRC_HW;
                end
            end
        end else begin
            st_d.pend = 1'b0;
            st_d.stop = 1'b0;
            if (sw_req) begin
                load      = 1'b1;
                st_d.busy = 1'b1;
                st_d.src  = SRC_SW;
            end else if (hw_req && hwen) begin
                load      = 1'b1;
                st_d.busy = 1'b1;
                st_d.src  = SRC_HW;
            end
        end

        auto_clr = abort || (blk_end && !aim);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{busy: 1'b0, done: 1'b0, pend: 1'b0, stop: 1'b0, src: SRC_HW};
        else        st_q <= st_d;
    end

    assign busy     = st_q.busy;
    assign blk_done = st_q.done;
endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_wr,
    input  logic [CNT_W-1:0] pkt_cnt,
    input  logic             aim_wr,
    input  logic             aim_val,
    input  logic             hwen_set,
    input  logic             hwen_clr,
    input  logic             sw_req,
    input  logic             chan_dis,
    input  logic             hw_req,
    input  logic             bus_err,
    output logic             busy,
    output logic             blk_done,
    output logic             hwen
);
    localparam logic [CNT_W-1:0] MIN_CNT = CNT_W'(1);

    typedef struct packed {
        logic             aim;
        logic [CNT_W-1:0] pkt;
    } cfg_st_t;

    cfg_st_t cfg_d, cfg_q;

    logic             cnt_load;
    logic             cnt_last;
    logic             hwen_auto_clr;
    logic [CNT_W-1:0] load_val;

    always_comb begin
        cfg_d = cfg_q;
        if (aim_wr) cfg_d.aim = aim_val;
        if (pkt_wr) cfg_d.pkt = pkt_cnt;
        load_val = (cfg_q.pkt == '0) ? MIN_CNT : cfg_q.pkt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    dma_hwen_reg u_hwen (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_req  (hwen_set),
        .clr_req  (hwen_clr),
        .auto_clr (hwen_auto_clr),
        .en       (hwen)
    );

    dma_elem_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (load_val),
        .run      (busy),
        .last     (cnt_last)
    );

    dma_chan_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_req   (sw_req),
        .hw_req   (hw_req),
        .chan_dis (chan_dis),
        .bus_err  (bus_err),
        .hwen     (hwen),
        .hwen_clr (hwen_clr),
        .aim      (cfg_q.aim),
        .last     (cnt_last),
        .busy     (busy),
        .blk_done (blk_done),
        .load     (cnt_load),
        .auto_clr (hwen_auto_clr)
    );
endmodule

// File: rtl/dma_chan_ctl_chk.sv
module dma_chan_ctl_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic blk_done,
    input logic hwen,
    input logic hwen_clr,
    input logic bus_err,
    input logic sw_req,
    input logic aim
);
    p_clear_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hwen_clr |=> !hwen);

    p_done_after_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |-> $past(busy));

    p_idle_no_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !blk_done);

    p_aim_keeps_hwen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (aim && hwen && !hwen_clr && !(busy && bus_err)) |=> hwen);

    p_no_hw_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !sw_req && !hwen) |=> !busy);

    p_bus_err_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_err) |=> (!busy && !hwen && !blk_done));
endmodule

bind dma_chan_ctl dma_chan_ctl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .blk_done (blk_done),
    .hwen     (hwen),
    .hwen_clr (hwen_clr),
    .bus_err  (bus_err),
    .sw_req   (sw_req),
    .aim      (cfg_q.aim)
);

// File: tb/dma_chan_ctl_test.sv
module dma_chan_ctl_test;
    localparam int CNT_W = 5;
    localparam int MAXC  = (1 << CNT_W) - 1;
    localparam int WIN   = 20;
    localparam int NV    = 8;

    typedef struct packed {
        logic       use_sw;
        logic       aim;
        logic       en;
        logic [4:0] n;
        logic [4:0] exp_done;
        logic       exp_hwen;
    } vec_t;

    // window of WIN cycles after the start edge; dones = floor(WIN/N) when restarting
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 1'b0, 5'd3, 5'd1,  1'b0},  // R8 single software block
        '{1'b1, 1'b1, 1'b0, 5'd4, 5'd5,  1'b0},  // R7 restarts every 4
        '{1'b0, 1'b0, 1'b1, 5'd5, 5'd1,  1'b0},  // R4 hw block, enable drops
        '{1'b0, 1'b1, 1'b1, 5'd3, 5'd1,  1'b1},  // R5 hw block, enable kept
        '{1'b0, 1'b1, 1'b0, 5'd2, 5'd0,  1'b0},  // R6 no enable, no block
        '{1'b1, 1'b1, 1'b0, 5'd5, 5'd4,  1'b0},  // R7 restarts every 5
        '{1'b1, 1'b0, 1'b1, 5'd2, 5'd1,  1'b0},  // R4 sw block clears enable
        '{1'b1, 1'b1, 1'b0, 5'd0, 5'd20, 1'b0}   // R3 count 0 acts as 1
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pkt_wr = 1'b0;
    logic [CNT_W-1:0] pkt_cnt = '0;
    logic             aim_wr = 1'b0;
    logic             aim_val = 1'b0;
    logic             hwen_set = 1'b0;
    logic             hwen_clr = 1'b0;
    logic             sw_req = 1'b0;
    logic             chan_dis = 1'b0;
    logic             hw_req = 1'b0;
    logic             bus_err = 1'b0;
    logic             busy;
    logic             blk_done;
    logic             hwen;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    dma_chan_ctl #(.CNT_W(CNT_W)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .pkt_wr   (pkt_wr),
        .pkt_cnt  (pkt_cnt),
        .aim_wr   (aim_wr),
        .aim_val  (aim_val),
        .hwen_set (hwen_set),
        .hwen_clr (hwen_clr),
        .sw_req   (sw_req),
        .chan_dis (chan_dis),
        .hw_req   (hw_req),
        .bus_err  (bus_err),
        .busy     (busy),
        .blk_done (blk_done),
        .hwen     (hwen)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_pkt(input int n);
        pkt_cnt = CNT_W'(n); pkt_wr = 1'b1;
        @(negedge clk); pkt_wr = 1'b0;
    endtask

    task automatic set_aim(input logic a);
        aim_val = a; aim_wr = 1'b1;
        @(negedge clk); aim_wr = 1'b0;
    endtask

    task automatic pulse_set();
        hwen_set = 1'b1; @(negedge clk); hwen_set = 1'b0;
    endtask

    task automatic pulse_sw();
        sw_req = 1'b1; @(negedge clk); sw_req = 1'b0;
    endtask

    task automatic pulse_hw();
        hw_req = 1'b1; @(negedge clk); hw_req = 1'b0;
    endtask

    task automatic count_done(input int n, output int dones);
        dones = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (blk_done) dones++;
        end
    endtask

    task automatic cleanup();
        chan_dis = 1'b1; hwen_clr = 1'b1;
        @(negedge clk); chan_dis = 1'b0; hwen_clr = 1'b0;
        for (int i = 0; i < 40 && busy; i++) @(negedge clk);
        cyc(2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int d;
        cyc(3);
        // R1 reset state
        check(busy == 1'b0, "R1 busy after reset", busy, 0);
        check(blk_done == 1'b0, "R1 done after reset", blk_done, 0);
        check(hwen == 1'b0, "R1 hwen after reset", hwen, 0);
        rst_n = 1'b1;
        cyc(2);

        // table walk
        for (int v = 0; v < NV; v++) begin
            set_pkt(int'(VECS[v].n));
            set_aim(VECS[v].aim);
            if (VECS[v].en) pulse_set();
            if (VECS[v].use_sw) pulse_sw(); else pulse_hw();
            count_done(WIN, d);
            check(d == int'(VECS[v].exp_done), $sformatf("R3/R4/R5/R6/R7/R8 vector %0d done count", v),
                  d, int'(VECS[v].exp_done));
            check(hwen == VECS[v].exp_hwen, $sformatf("R4/R5 vector %0d hwen", v),
                  hwen, int'(VECS[v].exp_hwen));
            cleanup();
        end

        // R2 set and clear together: clear wins
        hwen_set = 1'b1; hwen_clr = 1'b1;
        @(negedge clk); hwen_set = 1'b0; hwen_clr = 1'b0;
        check(hwen == 1'b0, "R2 set+clear same cycle", hwen, 0);
        pulse_set();
        check(hwen == 1'b1, "R2 set alone", hwen, 1);
        cleanup();

        // R3 largest count timing
        set_aim(1'b0);
        set_pkt(MAXC);
        pulse_sw();
        cyc(MAXC - 1);
        check(busy && !blk_done, "R3 busy before last count", {busy, blk_done}, 2);
        cyc(1);
        check(!busy && blk_done, "R3 done at full count", {busy, blk_done}, 1);
        cyc(1);
        check(!blk_done, "R3 done is one cycle", blk_done, 0);
        cleanup();

        // R5 repeated hw requests with enable kept
        set_aim(1'b1);
        set_pkt(3);
        pulse_set();
        pulse_hw();
        count_done(6, d);
        pulse_hw();
        begin
            int d2;
            count_done(6, d2);
            d = d + d2;
        end
        check(d == 2, "R5 two hw requests give two blocks", d, 2);
        check(!busy, "R5 idle after hw block", busy, 0);
        check(hwen == 1'b1, "R5 hwen kept", hwen, 1);

        // R10 pending hw request served when enable kept
        set_pkt(4);
        pulse_hw();
        pulse_hw();
        count_done(11, d);
        check(d == 2, "R10 pending request served", d, 2);
        cyc(2);
        // R10 with auto-repeat off: pending dropped, enable cleared (R4)
        set_aim(1'b0);
        pulse_hw();
        pulse_hw();
        count_done(11, d);
        check(d == 1, "R10 pending dropped when hwen cleared", d, 1);
        check(hwen == 1'b0, "R4 hwen cleared at block end", hwen, 0);
        cleanup();

        // R9 bus error aborts
        set_aim(1'b1);
        set_pkt(6);
        pulse_set();
        pulse_sw();
        cyc(1);
        bus_err = 1'b1; @(negedge clk); bus_err = 1'b0;
        check(!busy, "R9 busy cleared by bus error", busy, 0);
        check(hwen == 1'b0, "R9 hwen cleared by bus error", hwen, 0);
        count_done(15, d);
        check(d == 0, "R9 no done after abort", d, 0);
        // R9 idle bus error ignored
        pulse_set();
        bus_err = 1'b1; @(negedge clk); bus_err = 1'b0;
        cyc(1);
        check(hwen == 1'b1, "R9 idle bus error keeps hwen", hwen, 1);
        cleanup();

        // R7 disable stops restarts at boundary
        set_pkt(4);
        pulse_sw();
        chan_dis = 1'b1; @(negedge clk); chan_dis = 1'b0;
        count_done(10, d);
        check(d == 1, "R7 disable lets one block finish", d, 1);
        check(!busy, "R7 idle after disable", busy, 0);

        // R8 sw request while busy ignored
        set_aim(1'b0);
        pulse_sw();
        pulse_sw();
        count_done(10, d);
        check(d == 1, "R8 sw request while busy ignored", d, 1);
        check(!busy, "R8 idle after single block", busy, 0);

        // R11 software wins over hardware when both arrive
        set_aim(1'b1);
        set_pkt(3);
        pulse_set();
        sw_req = 1'b1; hw_req = 1'b1;
        @(negedge clk); sw_req = 1'b0; hw_req = 1'b0;
        count_done(12, d);
        check(d == 4, "R11 simultaneous start treated as software", d, 4);
        cleanup();

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule